// File: doc/BRIEF.md
# Toggle-Serviced Watchdog Timer

This block supervises a processor by watching one service line. The processor must change the level of that line, in either direction, before a programmable number of clock cycles has gone by. If the line stays high or stays low for the whole window, the block issues a single-cycle timeout strobe to the reset generator. A rising edge and a falling edge are equally valid as service.

The service line comes from outside the clock domain. It passes through a two-flop synchronizer, and a level change is found by comparing the synchronized value with its previous sample. While the system reset is active, the counter is forced to zero and does not count. When the system reset is released, the counter starts again from zero. A disable flag stands for the case where the service line is left unconnected. While the flag is set, the counter is held at zero, so the block can never time out. When the flag is cleared, counting starts again from zero. After a strobe, the counter saturates. It strobes again only after a new service edge or a clear.

Top module: `wdt_toggle_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, `timeout_strobe` is 0 after that edge and the counter is cleared. With the inputs quiet, the first strobe comes exactly `TIMEOUT_CYCLES` rising edges after `rst_n` is released.
- R2: After a clear, if `wdog_in` does not change, `timeout_strobe` is 1 after exactly the `TIMEOUT_CYCLES`-th rising clock edge without a clear, and is 0 after every earlier edge.
- R3: `timeout_strobe` is high for one cycle only. While `wdog_in` stays at the same level after a strobe, no further strobe comes, however long the line stays quiet.
- R4: A low-to-high change of `wdog_in` restarts the count. The counter is zero after the third rising clock edge that samples the new level, so the next strobe comes `TIMEOUT_CYCLES + 3` edges after that first sampling edge.
- R5: A high-to-low change of `wdog_in` restarts the count with the same latency as R4.
- R6: A high level on `wdog_in` that lasts one clock cycle counts as two service edges. The strobe then comes `TIMEOUT_CYCLES + 4` edges after the edge that first samples the high level.
- R7: While `sys_reset_active` is 1, the counter is held at zero and `timeout_strobe` stays 0, for any length of time.
- R8: Once `sys_reset_active` falls, counting starts from zero. The strobe comes `TIMEOUT_CYCLES` edges after the release if the line stays quiet.
- R9: While `wdog_disable` is 1, the counter is held at zero and `timeout_strobe` never rises.
- R10: Once `wdog_disable` falls, counting starts from zero. The strobe comes `TIMEOUT_CYCLES` edges after the release if the line stays quiet.
- R11: After a strobe, a new service edge arms the timer again, and it strobes again after a further quiet window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; its period must be shorter than the narrowest service pulse |
| rst_n | input | 1 | Synchronous active-low block reset |
| wdog_in | input | 1 | Asynchronous service line from the processor |
| sys_reset_active | input | 1 | High while the system reset is asserted; freezes the counter at zero |
| wdog_disable | input | 1 | High when the service line is treated as unconnected; holds the counter at zero |
| timeout_strobe | output | 1 | One-cycle pulse when the service window expires |

## Verification
The timer is driven with a line that stays quiet after each kind of clear (block reset, system-reset release, disable release). The strobe position must match the window exactly, which shows that each clear restarts the count from zero. A single rising change and a single falling change are applied separately, each from the saturated state. Each one must restart the count with a three-edge lag, which separates edge detection in both directions from level detection. A one-cycle high pulse must move the strobe by one more edge than a single change does, which shows that the trailing edge is also counted. Long quiet stretches after a strobe, during system reset and under disable must give no strobe at all. This exposes a counter that wraps around or keeps running.

// File: rtl/wdt_pkg.sv
// Shared types for the toggle-serviced watchdog.
// Assumes: single clock domain after the input synchronizer.
package wdt_pkg;

    // Reasons the timeout counter is forced to zero in a cycle.
    typedef struct packed {
        logic blk_reset;   // block reset low
        logic sys_reset;   // system reset active
        logic disabled;    // service line treated as floating
        logic serviced;    // level change seen on the service line
    } wdt_clear_t;

    // True when any clear reason is present.
    function automatic logic wdt_any_clear(input wdt_clear_t c);
        return c.blk_reset | c.sys_reset | c.disabled | c.serviced;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: input pulses last longer than one clock period.
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level on one stage to let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/wdt_edge_det.sv
// Reports any level change (rising or falling) of a synchronized input.
// Assumes: the input is already in the clk domain.
module wdt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic changed
);
    logic level_d;

    // Keep the previous sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign changed = level ^ level_d;
endmodule

// File: rtl/wdt_counter.sv
// Saturating quiet-time counter with a registered one-cycle expiry pulse.
// Assumes: LIMIT >= 2; clear has priority over counting.
module wdt_counter #(
    parameter int LIMIT = 80_000_000
) (
    input  logic clk,
    input  logic clear,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(LIMIT);
    localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Count quiet cycles, stop at the limit, restart on clear.
    always_ff @(posedge clk) begin
        if (clear)               cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Pulse once when the count reaches the limit.
    always_ff @(posedge clk) begin
        if (clear) expire <= 1'b0;
        else       expire <= (cnt == CNT_LAST);
    end
endmodule

// File: rtl/wdt_toggle_watchdog.sv
// Toggle-serviced watchdog: strobes when the service line has not
// changed level for TIMEOUT_CYCLES clock cycles.
// Assumes: synchronous active-low rst_n; clk fast enough to sample the
// narrowest service pulse.
module wdt_toggle_watchdog
    import wdt_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 80_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdog_in,
    input  logic sys_reset_active,
    input  logic wdog_disable,
    output logic timeout_strobe
);
    logic       svc_level;
    logic       svc_edge;
    wdt_clear_t clr;

    wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wdog_in),
        .sync_out (svc_level)
    );

    wdt_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (svc_level),
        .changed (svc_edge)
    );

    // Gather every reason to restart the window.
    always_comb begin
        clr.blk_reset = !rst_n;
        clr.sys_reset = sys_reset_active;
        clr.disabled  = wdog_disable;
        clr.serviced  = svc_edge;
    end

    wdt_counter #(.LIMIT(TIMEOUT_CYCLES)) u_cnt (
        .clk    (clk),
        .clear  (wdt_any_clear(clr)),
        .expire (timeout_strobe)
    );
endmodule

// File: rtl/wdt_toggle_watchdog_chk.sv
// Property checker for the toggle-serviced watchdog, bound to the top.
module wdt_toggle_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic wdog_in,
    input logic sys_reset_active,
    input logic wdog_disable,
    input logic timeout_strobe
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !timeout_strobe);

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_strobe |=> !timeout_strobe);

    // Covers both directions of change: R4 and R5.
    a_r4_service_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_in != $past(wdog_in)) |-> ##3 !timeout_strobe);

    a_r7_frozen_in_sysreset: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_active |=> !timeout_strobe);

    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_disable |=> !timeout_strobe);
endmodule

bind wdt_toggle_watchdog wdt_toggle_watchdog_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wdog_in          (wdog_in),
    .sys_reset_active (sys_reset_active),
    .wdog_disable     (wdog_disable),
    .timeout_strobe   (timeout_strobe)
);

// File: tb/tb_wdt_toggle_watchdog.sv
`timescale 1ns/1ps
module tb_wdt_toggle_watchdog;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst_n, wdog_in, sys_reset_active, wdog_disable;
    logic timeout_strobe;
    int   n_checks = 0;
    int   n_fail   = 0;

    always #10 clk = ~clk;

    wdt_toggle_watchdog #(.TIMEOUT_CYCLES(T)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .wdog_in          (wdog_in),
        .sys_reset_active (sys_reset_active),
        .wdog_disable     (wdog_disable),
        .timeout_strobe   (timeout_strobe)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: timeout_strobe=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Step n edges; the strobe is expected only after edge number at (0 = never).
    task automatic watch(input int n, input int at, input string req);
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); @(negedge clk);
            check(timeout_strobe, (k == at), req);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wdog_in = 1'b0; sys_reset_active = 1'b1; wdog_disable = 1'b0;
        repeat (3) @(negedge clk);
        check(timeout_strobe, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sysrst_release_timeout();
        sys_reset_active = 1'b0;
        watch(T + 5, T, "R2 R8 quiet window");
    endtask

    task automatic t_saturate();
        watch(3 * T, 0, "R3 no repeat strobe");
    endtask

    task automatic t_block_reset_midcount();
        watch(T / 2, 0, "R1 partial count");
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(timeout_strobe, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        watch(T + 3, T, "R1 count from zero");
    endtask

    task automatic t_rise_service();
        wdog_in = 1'b1;
        watch(T + 6, T + 3, "R4 R11 rising service");
    endtask

    task automatic t_fall_service();
        wdog_in = 1'b0;
        watch(T + 6, T + 3, "R5 falling service");
    endtask

    task automatic t_midcount_service();
        wdog_in = 1'b1;
        watch(T - 5, 0, "R4 partial");
        wdog_in = 1'b0;
        watch(T + 6, T + 3, "R5 service mid count");
    endtask

    task automatic t_short_pulse();
        wdog_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(timeout_strobe, 1'b0, "R6 pulse start");
        wdog_in = 1'b0;
        watch(T + 6, T + 3, "R6 short pulse");
    endtask

    task automatic t_sysrst_hold();
        sys_reset_active = 1'b1;
        watch(3 * T, 0, "R7 held in sys reset");
        sys_reset_active = 1'b0;
        watch(T + 3, T, "R8 restart after sys reset");
    endtask

    task automatic t_disable_hold();
        wdog_disable = 1'b1;
        wdog_in = 1'b1;
        watch(3 * T, 0, "R9 disabled");
        wdog_disable = 1'b0;
        watch(T + 3, T, "R10 restart after disable");
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sysrst_release_timeout();
        t_saturate();
        t_block_reset_midcount();
        t_rise_service();
        t_fall_service();
        t_midcount_service();
        t_short_pulse();
        t_sysrst_hold();
        t_disable_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule